// File: doc/BRIEF.md
# Banked Byte Memory Router with Pointer Access

This block sits between a small processor core and its data storage. Each access names a location in one of two ways. The first is a 7-bit offset inside the bank chosen by a 5-bit bank register. The second is a 16-bit pointer. The block decodes the resulting 12-bit data address and sends the access to one of four places:

- the core register file, which is the same set of registers seen from every bank;
- a window of peripheral registers, which is private to each bank;
- general-purpose RAM, which is private to each bank;
- a small common RAM, which every bank sees at the same offsets.

The core registers and the peripheral window live outside the block and are reached through ports. The general-purpose RAM and the common RAM are stored inside the block.

When the pointer has its top bit set, the access goes to a read-only program memory port instead of data memory. The read returns the low byte of the addressed program word and takes one extra cycle, which the block signals on a stall output. A write with such a pointer is dropped.

A data read returns its byte one cycle after the request is taken. A program memory read returns its byte two cycles after the request is taken. The requester must not present a new access while stall is high; the block ignores any request seen during that cycle.

Top module: `banked_mem_router`

## Requirements
- R1: Offsets 0x00 to 0x0B select the core register port, with `core_idx` equal to the offset and with the same index in every bank. A write reaches that register and a read returns `core_rdata`.
- R2: Offsets 0x0C to 0x1F select the peripheral port, with `per_bank` equal to the bank and `per_idx` equal to the offset minus 0x0C. Each bank therefore reaches different peripheral registers.
- R3: Offsets 0x20 to 0x6F in banks below `GPR_BANKS` (default 2) reach internal RAM that is private to each bank. A write there is returned by later reads of the same bank and offset.
- R4: Offsets 0x20 to 0x6F in banks at or above `GPR_BANKS` read as 0. Writes to them change no storage in any bank.
- R5: Offsets 0x70 to 0x7F reach one 16-byte common RAM. A write made from any bank is read back from every bank.
- R6: In a pointer access with bit 15 clear, pointer bits 11:7 give the bank and bits 6:0 give the offset. Pointer bits 14:12 are ignored and the bank register is not used.
- R7: A pointer read with bit 15 set does the following:
  - it drives `pm_addr` with pointer bits 10:0 and raises `pm_re` for one cycle;
  - stall is high for exactly that one cycle after the request is taken;
  - two cycles after the request is taken, it returns bits 7:0 of `pm_rdata` with `rd_valid` high.
- R8: A pointer write with bit 15 set has no effect. It raises no stall and no `pm_re`, and it writes no core, peripheral or RAM location.
- R9: A data read sets `rd_valid` high for one cycle, one cycle after the request, and `stall` stays low. After reset `rd_valid`, `stall` and `rd_data` are 0 and both internal RAMs read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | Use `ind_ptr` instead of bank register and offset |
| bank_sel | input | 5 | Bank register value for direct accesses |
| req_offset | input | 7 | Offset within bank for direct accesses |
| ind_ptr | input | 16 | Pointer; bit 15 selects program memory |
| wr_data | input | 8 | Write data, also seen by the external register files |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data, held until the next read |
| stall | output | 1 | Program memory fetch in progress |
| core_idx | output | 4 | Core register index |
| core_we | output | 1 | Core register write strobe |
| core_re | output | 1 | Core register read strobe |
| core_rdata | input | 8 | Core register read value |
| per_bank | output | 5 | Peripheral bank |
| per_idx | output | 5 | Peripheral index within window |
| per_we | output | 1 | Peripheral write strobe |
| per_re | output | 1 | Peripheral read strobe |
| per_rdata | input | 8 | Peripheral read value |
| pm_addr | output | 11 | Program memory word address |
| pm_re | output | 1 | Program memory read strobe |
| pm_rdata | input | 14 | Program memory word |

## Verification
The assertions check the following on every cycle:
- at most one target strobe fires;
- a stall never lasts beyond one cycle and is always followed by valid data;
- a taken data read yields `rd_valid` on the next cycle without a stall;
- a read of an unbacked RAM offset returns 0;
- a program memory write never stalls.

Only the bench scenarios can show where the data ends up:
- core registers are mirrored across banks while peripheral and RAM bytes stay per bank;
- common RAM is shared by all banks;
- pointer bits 14:12 are ignored;
- a dropped program memory write leaves the RAM byte that shares its low address bits unchanged.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

   typedef enum logic [2:0] {
      RG_CORE   = 3'd0,
      RG_PERIPH = 3'd1,
      RG_GPR    = 3'd2,
      RG_COMMON = 3'd3,
      RG_NONE   = 3'd4,
      RG_PROG   = 3'd5
   } region_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bmr_decode.sv
module bmr_decode
   import bmr_pkg::*;
#(
   parameter int BANK_W    = 5,
   parameter int OFS_W     = 7,
   parameter int PTR_W     = 16,
   parameter int CORE_N    = 12,
   parameter int PERIPH_N  = 20,
   parameter int GPR_N     = 80,
   parameter int COMMON_N  = 16,
   parameter int GPR_BANKS = 2,
   localparam int CORE_IW  = idx_w(CORE_N),
   localparam int PER_IW   = idx_w(PERIPH_N),
   localparam int GPR_IW   = idx_w(GPR_N * GPR_BANKS),
   localparam int COM_IW   = idx_w(COMMON_N)
)(
   input  logic                req_indirect,
   input  logic [BANK_W-1:0]   bank_sel,
   input  logic [OFS_W-1:0]    req_offset,
   input  logic [PTR_W-1:0]    ind_ptr,
   output region_e             region,
   output logic [BANK_W-1:0]   bank,
   output logic [CORE_IW-1:0]  core_idx,
   output logic [PER_IW-1:0]   per_idx,
   output logic [GPR_IW-1:0]   gpr_idx,
   output logic [COM_IW-1:0]   com_idx
);

   localparam int LO_PER = CORE_N;
   localparam int LO_GPR = LO_PER + PERIPH_N;
   localparam int LO_COM = LO_GPR + GPR_N;
   localparam int LO_END = LO_COM + COMMON_N;

   logic [OFS_W-1:0] ofs;
   int               o;
   logic             to_prog;

   always_comb begin
      to_prog  = req_indirect && ind_ptr[PTR_W-1];
      bank     = req_indirect ? ind_ptr[BANK_W+OFS_W-1:OFS_W] : bank_sel;
      ofs      = req_indirect ? ind_ptr[OFS_W-1:0] : req_offset;
      o        = int'(ofs);
      region   = RG_NONE;
      core_idx = '0;
      per_idx  = '0;
      gpr_idx  = '0;
      com_idx  = '0;
      if (to_prog) begin
         region = RG_PROG;
      end else if (o < LO_PER) begin
         region   = RG_CORE;
         core_idx = CORE_IW'(o);
      end else if (o < LO_GPR) begin
         region  = RG_PERIPH;
         per_idx = PER_IW'(o - LO_PER);
      end else if (o < LO_COM) begin
         if (int'(bank) < GPR_BANKS) begin
            region  = RG_GPR;
            gpr_idx = GPR_IW'(int'(bank) * GPR_N + o - LO_GPR);
         end
      end else if (o < LO_END) begin
         region  = RG_COMMON;
         com_idx = COM_IW'(o - LO_COM);
      end
   end

endmodule

// File: rtl/bmr_bytes.sv
module bmr_bytes
   import bmr_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter bit CLEAR  = 1'b1,
   localparam int AW    = idx_w(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && int'(addr) < DEPTH) begin
               mem[addr] <= wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we && int'(addr) < DEPTH) mem[addr] <= wdata;
         end
      end
   endgenerate

   assign rdata = (int'(addr) < DEPTH) ? mem[addr] : '0;

   // R3: writes only land on backed bytes
   p_wr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(addr) < DEPTH));

endmodule

// File: rtl/bmr_pm_port.sv
module bmr_pm_port #(
   parameter int PM_AW = 11
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PM_AW-1:0] word,
   output logic [PM_AW-1:0] pm_addr,
   output logic             pm_re,
   output logic             stall
);

   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         pm_addr <= '0;
      end else begin
         pend <= start;
         if (start) pm_addr <= word;
      end
   end

   assign pm_re = pend;
   assign stall = pend;

   p_stall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   p_no_start_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !start);

endmodule

// File: rtl/banked_mem_router.sv
module banked_mem_router
   import bmr_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BANK_W    = 5,
   parameter int OFS_W     = 7,
   parameter int PTR_W     = 16,
   parameter int CORE_N    = 12,
   parameter int PERIPH_N  = 20,
   parameter int GPR_N     = 80,
   parameter int COMMON_N  = 16,
   parameter int GPR_BANKS = 2,
   parameter int PM_AW     = 11,
   parameter int PM_DW     = 14,
   parameter bit MEM_CLEAR = 1'b1,
   localparam int CORE_IW  = idx_w(CORE_N),
   localparam int PER_IW   = idx_w(PERIPH_N),
   localparam int GPR_D    = GPR_N * GPR_BANKS,
   localparam int GPR_IW   = idx_w(GPR_D),
   localparam int COM_IW   = idx_w(COMMON_N)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_indirect,
   input  logic [BANK_W-1:0]  bank_sel,
   input  logic [OFS_W-1:0]   req_offset,
   input  logic [PTR_W-1:0]   ind_ptr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   output logic               stall,
   output logic [CORE_IW-1:0] core_idx,
   output logic               core_we,
   output logic               core_re,
   input  logic [DATA_W-1:0]  core_rdata,
   output logic [BANK_W-1:0]  per_bank,
   output logic [PER_IW-1:0]  per_idx,
   output logic               per_we,
   output logic               per_re,
   input  logic [DATA_W-1:0]  per_rdata,
   output logic [PM_AW-1:0]   pm_addr,
   output logic               pm_re,
   input  logic [PM_DW-1:0]   pm_rdata
);

   initial begin : elab_checks
      if (CORE_N + PERIPH_N + GPR_N + COMMON_N != (1 << OFS_W))
         $fatal(1, "bank regions must fill the offset space");
      if (BANK_W + OFS_W > PTR_W - 2)
         $fatal(1, "pointer too narrow for data address");
      if (PM_AW > PTR_W - 1 || PM_DW <= DATA_W)
         $fatal(1, "program memory port widths inconsistent");
      if (GPR_BANKS < 1 || GPR_BANKS > (1 << BANK_W))
         $fatal(1, "GPR_BANKS out of range");
   end

   region_e             region;
   logic [BANK_W-1:0]   bank;
   logic [GPR_IW-1:0]   gpr_idx;
   logic [COM_IW-1:0]   com_idx;
   logic [DATA_W-1:0]   gpr_rd, com_rd, sel_rd;
   logic                accept, is_rd, gpr_we, com_we, pm_start;
   logic                unused_bits;

   assign unused_bits = ^{ind_ptr[PTR_W-2:BANK_W+OFS_W], pm_rdata[PM_DW-1:DATA_W]};

   bmr_decode #(
      .BANK_W(BANK_W), .OFS_W(OFS_W), .PTR_W(PTR_W), .CORE_N(CORE_N),
      .PERIPH_N(PERIPH_N), .GPR_N(GPR_N), .COMMON_N(COMMON_N),
      .GPR_BANKS(GPR_BANKS)
   ) u_dec (
      .req_indirect(req_indirect), .bank_sel(bank_sel), .req_offset(req_offset),
      .ind_ptr(ind_ptr), .region(region), .bank(bank), .core_idx(core_idx),
      .per_idx(per_idx), .gpr_idx(gpr_idx), .com_idx(com_idx)
   );

   assign accept   = req_valid && !stall;
   assign is_rd    = accept && !req_write;
   assign core_we  = accept && req_write && region == RG_CORE;
   assign core_re  = is_rd && region == RG_CORE;
   assign per_we   = accept && req_write && region == RG_PERIPH;
   assign per_re   = is_rd && region == RG_PERIPH;
   assign gpr_we   = accept && req_write && region == RG_GPR;
   assign com_we   = accept && req_write && region == RG_COMMON;
   assign pm_start = is_rd && region == RG_PROG;
   assign per_bank = bank;

   bmr_bytes #(.DEPTH(GPR_D), .DATA_W(DATA_W), .CLEAR(MEM_CLEAR)) u_gpr (
      .clk(clk), .rst_n(rst_n), .we(gpr_we), .addr(gpr_idx),
      .wdata(wr_data), .rdata(gpr_rd)
   );

   bmr_bytes #(.DEPTH(COMMON_N), .DATA_W(DATA_W), .CLEAR(MEM_CLEAR)) u_com (
      .clk(clk), .rst_n(rst_n), .we(com_we), .addr(com_idx),
      .wdata(wr_data), .rdata(com_rd)
   );

   bmr_pm_port #(.PM_AW(PM_AW)) u_pm (
      .clk(clk), .rst_n(rst_n), .start(pm_start),
      .word(ind_ptr[PM_AW-1:0]), .pm_addr(pm_addr), .pm_re(pm_re), .stall(stall)
   );

   always_comb begin
      case (region)
         RG_CORE:   sel_rd = core_rdata;
         RG_PERIPH: sel_rd = per_rdata;
         RG_GPR:    sel_rd = gpr_rd;
         RG_COMMON: sel_rd = com_rd;
         default:   sel_rd = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else if (stall) begin
         rd_valid <= 1'b1;
         rd_data  <= pm_rdata[DATA_W-1:0];
      end else if (is_rd && region != RG_PROG) begin
         rd_valid <= 1'b1;
         rd_data  <= sel_rd;
      end else begin
         rd_valid <= 1'b0;
      end
   end

   // R2: a single target sees each access
   p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({core_we, core_re, per_we, per_re, gpr_we, com_we, pm_start}));

   p_unbacked_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && region == RG_NONE) |=> (rd_valid && rd_data == '0));

   p_pm_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> rd_valid);

   p_pm_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_write && req_indirect && ind_ptr[PTR_W-1]) |=> !stall);

   p_read_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && region != RG_PROG) |=> (rd_valid && !stall));

endmodule

// File: tb/sim_banked_mem_router.sv
`timescale 1ns/1ps
module sim_banked_mem_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_indirect = 1'b0;
   logic [4:0]  bank_sel = '0;
   logic [6:0]  req_offset = '0;
   logic [15:0] ind_ptr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_valid, stall, core_we, core_re, per_we, per_re, pm_re;
   logic [7:0]  rd_data, core_rdata, per_rdata;
   logic [3:0]  core_idx;
   logic [4:0]  per_bank, per_idx;
   logic [10:0] pm_addr;
   logic [13:0] pm_rdata;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #2 clk = ~clk;

   banked_mem_router u0 (.*);

   // external register files driven by the DUT strobes
   logic [7:0] ext_core [16];
   logic [7:0] ext_per  [640];
   // bench reference state
   logic [7:0] exp_core [12];
   logic [7:0] exp_per  [640];
   logic [7:0] exp_gpr  [160];
   logic [7:0] exp_com  [16];

   function automatic int per_slot(input logic [4:0] b, input logic [4:0] i);
      int s = int'(b) * 20 + int'(i);
      return (s < 640) ? s : 0;
   endfunction

   function automatic logic [13:0] pm_word(input logic [10:0] a);
      return 14'((int'(a) * 73) ^ 14'h2A5);
   endfunction

   always_comb begin
      core_rdata = ext_core[core_idx];
      per_rdata  = ext_per[per_slot(per_bank, per_idx)];
      pm_rdata   = pm_word(pm_addr);
   end

   always @(posedge clk) begin
      if (core_we) ext_core[core_idx] <= wr_data;
      if (per_we)  ext_per[per_slot(per_bank, per_idx)] <= wr_data;
   end

   function automatic string tag_of(input int o, input int b);
      if (o < 12)  return "R1";
      if (o < 32)  return "R2";
      if (o < 112) return (b < 2) ? "R3" : "R4";
      return "R5";
   endfunction

   function automatic logic [7:0] exp_read(input int b, input int o);
      if (o < 12)  return exp_core[o];
      if (o < 32)  return exp_per[b * 20 + o - 12];
      if (o < 112) return (b < 2) ? exp_gpr[b * 80 + o - 32] : 8'h00;
      return exp_com[o - 112];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one access; returns after its result is visible
   task automatic access(input bit wr, input bit ind, input logic [4:0] b,
                         input logic [6:0] o, input logic [15:0] p,
                         input logic [7:0] d, input string extra);
      bit   prog = ind && p[15];
      int   eb   = ind ? int'(p[11:7]) : int'(b);
      int   eo   = ind ? int'(p[6:0])  : int'(o);
      string t   = (extra != "") ? extra : tag_of(eo, eb);
      logic [7:0] e = prog ? pm_word(p[10:0])[7:0] : exp_read(eb, eo);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_indirect = ind;
      bank_sel = b; req_offset = o; ind_ptr = p; wr_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      if (prog && !wr) begin
         chk(stall === 1'b1 && pm_re === 1'b1, "R7 stall", int'(stall), 1);
         chk(pm_addr === p[10:0], "R7 pm_addr", int'(pm_addr), int'(p[10:0]));
         @(negedge clk);
         chk(rd_valid === 1'b1 && stall === 1'b0, "R7 valid", int'(rd_valid), 1);
         chk(rd_data === e, "R7 data", int'(rd_data), int'(e));
      end else if (prog) begin
         chk(stall === 1'b0 && pm_re === 1'b0, "R8 quiet", int'(stall), 0);
      end else if (!wr) begin
         chk(rd_valid === 1'b1 && stall === 1'b0, {t, " R9 valid"}, int'(rd_valid), 1);
         chk(rd_data === e, t, int'(rd_data), int'(e));
      end else begin
         if (eo < 12)       exp_core[eo] = d;
         else if (eo < 32)  exp_per[eb * 20 + eo - 12] = d;
         else if (eo < 112) begin if (eb < 2) exp_gpr[eb * 80 + eo - 32] = d; end
         else               exp_com[eo - 112] = d;
      end
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected <150000", cyc);
         finish_run();
      end
   end

   initial begin
      int seed = 32'h5EED;
      void'($urandom(seed));
      for (int i = 0; i < 16; i++)  begin ext_core[i] = '0; exp_com[i] = '0; end
      for (int i = 0; i < 12; i++)  exp_core[i] = '0;
      for (int i = 0; i < 640; i++) begin ext_per[i] = '0; exp_per[i] = '0; end
      for (int i = 0; i < 160; i++) exp_gpr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(rd_valid === 1'b0 && stall === 1'b0 && rd_data === 8'h00, "R9 reset",
          int'({rd_valid, stall, rd_data}), 0);
      access(0, 0, 5'd1, 7'h45, 16'h0, 8'h0, "R9 cleared");
      // R1 core register mirrored
      access(1, 0, 5'd3, 7'h05, 16'h0, 8'hA7, "");
      access(0, 0, 5'd20, 7'h05, 16'h0, 8'h0, "R1");
      // R2 per-bank peripheral window
      access(1, 0, 5'd7, 7'h0C, 16'h0, 8'h3C, "");
      access(1, 0, 5'd8, 7'h1F, 16'h0, 8'hC3, "");
      access(0, 0, 5'd7, 7'h0C, 16'h0, 8'h0, "R2");
      access(0, 0, 5'd8, 7'h0C, 16'h0, 8'h0, "R2");
      access(0, 0, 5'd8, 7'h1F, 16'h0, 8'h0, "R2");
      // R3 GPR per bank, both edges
      access(1, 0, 5'd0, 7'h20, 16'h0, 8'h11, "");
      access(1, 0, 5'd1, 7'h20, 16'h0, 8'h22, "");
      access(1, 0, 5'd1, 7'h6F, 16'h0, 8'h6F, "");
      access(0, 0, 5'd0, 7'h20, 16'h0, 8'h0, "R3");
      access(0, 0, 5'd1, 7'h20, 16'h0, 8'h0, "R3");
      access(0, 0, 5'd1, 7'h6F, 16'h0, 8'h0, "R3");
      // R4 unbacked bank ignores writes
      access(1, 0, 5'd2, 7'h20, 16'h0, 8'hEE, "");
      access(0, 0, 5'd2, 7'h20, 16'h0, 8'h0, "R4");
      access(0, 0, 5'd0, 7'h20, 16'h0, 8'h0, "R4 no alias");
      // R5 common RAM shared
      access(1, 0, 5'd0, 7'h70, 16'h0, 8'h5A, "");
      access(1, 0, 5'd9, 7'h7F, 16'h0, 8'hA5, "");
      access(0, 0, 5'd31, 7'h70, 16'h0, 8'h0, "R5");
      access(0, 0, 5'd4, 7'h7F, 16'h0, 8'h0, "R5");
      // R6 pointer data access, high bits ignored, bank_sel unused
      access(1, 1, 5'd9, 7'h00, {1'b0, 3'b101, 5'd1, 7'h30}, 8'h99, "");
      access(0, 0, 5'd1, 7'h30, 16'h0, 8'h0, "R6");
      access(0, 1, 5'd0, 7'h00, {1'b0, 3'b010, 5'd1, 7'h30}, 8'h0, "R6");
      // R7 program memory read
      access(0, 1, 5'd0, 7'h00, 16'h8000, 8'h0, "");
      access(0, 1, 5'd0, 7'h00, 16'h87FF, 8'h0, "");
      // R8 program write dropped; low bits alias bank0 offset 0x20
      access(1, 1, 5'd0, 7'h00, 16'h8020, 8'hFF, "");
      access(0, 0, 5'd0, 7'h20, 16'h0, 8'h0, "R8 no side write");
      // random mix
      for (int n = 0; n < 1500; n++) begin
         bit          wr  = $urandom_range(0, 1) == 1;
         bit          ind = $urandom_range(0, 2) == 0;
         logic [4:0]  b   = ($urandom_range(0, 1) == 1) ? 5'($urandom_range(0, 2)) : 5'($urandom);
         logic [6:0]  o   = 7'($urandom);
         logic [15:0] p   = {($urandom_range(0, 7) == 0), 3'($urandom), b, o};
         access(wr, ind, 5'($urandom), ind ? 7'($urandom) : o, p, 8'($urandom), "");
      end
      finish_run();
   end

endmodule